// File: doc/BRIEF.md
# Registered ALU with Six Status Flags

This block is a 32-bit two-operand ALU that performs addition, subtraction, bitwise AND, OR and XOR, and reports six status flags with every result: carry, overflow, sign, zero, auxiliary carry and parity. It is meant to sit in an execution stage. The stage drives two operands, an operation code and a valid strobe. One clock later the block presents a registered result, the flags and an output valid.

For arithmetic, carry and overflow report an out-of-range result in unsigned and in signed terms. The auxiliary carry reports a carry into bit 4. On subtraction, both carry bits become borrows. Parity is evaluated over the low result byte only. Logical operations clear carry, overflow and auxiliary carry, so a consumer can read every flag the same way whatever operation produced it. When the input valid is low, the output registers keep their values.

Top module: `flag_alu`

## Requirements
- R1: While rst_ni is low, valid_o, result_o and all six flag outputs are 0.
- R2: valid_o is high in the cycle after a clock edge at which valid_i was high, and low otherwise. result_o and the flags then reflect the operands and op_i sampled at that edge.
- R3: op_i selects the operation: 0 gives a+b, 1 gives a-b, 2 gives a AND b, 3 gives a OR b, 4 gives a XOR b. Codes 5, 6 and 7 give a result of 0. Arithmetic wraps modulo 2^32.
- R4: carry_o is the carry out of bit 31 for addition. For subtraction it is the borrow, set when a < b as unsigned values.
- R5: overflow_o is set when the signed (two's complement) sum or difference does not fit in 32 bits.
- R6: sign_o equals bit 31 of result_o.
- R7: zero_o is set exactly when result_o is 0.
- R8: aux_o is the carry from bit 3 into bit 4 for addition. For subtraction it is the borrow out of the low nibble, set when a[3:0] < b[3:0].
- R9: parity_o is set when result_o[7:0] holds an even number of 1 bits. Bits 31:8 have no influence.
- R10: For op codes 2 to 7, carry_o, overflow_o and aux_o are 0.
- R11: At a clock edge where valid_i is low, result_o and all flags keep their previous values, whatever the operands and op_i are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and op_i are valid this cycle |
| op_i | input | 3 | Operation code (see R3) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (subtrahend for op 1) |
| valid_o | output | 1 | Registered result is new this cycle |
| result_o | output | 32 | Registered result |
| carry_o | output | 1 | Unsigned carry or borrow |
| overflow_o | output | 1 | Signed overflow |
| sign_o | output | 1 | Result bit 31 |
| zero_o | output | 1 | Result is zero |
| aux_o | output | 1 | Carry or borrow at the nibble boundary |
| parity_o | output | 1 | Even number of ones in the low result byte |

## Verification
Seeded random operands across all eight op codes cover the general case. Random 32-bit values rarely produce a zero result, a borrow with equal nibbles, or a signed overflow at the exact boundary, so these are driven as directed cases. The directed cases include 0x7FFFFFFF+1, 0xFFFFFFFF+1, 0-1 and 0x80000000-1. They tell apart carry from overflow and borrow from carry, and they show whether the nibble carry uses bit 4 or bit 3. A result with ones only above bit 7 shows whether parity is limited to the low byte. An idle cycle with changed operands tells holding apart from free-running capture.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
  } alu_flags_t;
endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith #(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned AUX_BIT = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cf_o,
  output logic             of_o,
  output logic             af_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  // subtract as a + ~b + 1
  assign b_eff = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + (WIDTH+1)'(sub_i);
  assign sum_o = full[MSB:0];

  // borrow is the inverted adder carry
  assign cf_o = full[WIDTH] ^ sub_i;
  assign af_o = a_i[AUX_BIT] ^ b_eff[AUX_BIT] ^ sum_o[AUX_BIT] ^ sub_i;
  assign of_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned PAR_BITS = 8
) (
  input  logic [WIDTH-1:0] res_i,
  output logic             sf_o,
  output logic             zf_o,
  output logic             pf_o
);
  logic [PAR_BITS-1:0] chain;

  assign chain[0] = res_i[0];
  for (genvar i = 1; i < PAR_BITS; i++) begin : g_par
    assign chain[i] = chain[i-1] ^ res_i[i];
  end

  assign pf_o = ~chain[PAR_BITS-1];
  assign sf_o = res_i[WIDTH-1];
  assign zf_o = (res_i == '0);
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned PAR_BITS = 8,
  parameter int unsigned AUX_BIT  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             overflow_o,
  output logic             sign_o,
  output logic             zero_o,
  output logic             aux_o,
  output logic             parity_o
);
  logic [WIDTH-1:0] sum, lres, res;
  logic             a_cf, a_of, a_af, is_arith;
  logic             sf, zf, pf;
  alu_flags_t       nxt, q;

  assign is_arith = (op_i == OP_ADD) || (op_i == OP_SUB);

  flag_alu_arith #(.WIDTH(WIDTH), .AUX_BIT(AUX_BIT)) arith_i (
    .a_i(a_i), .b_i(b_i), .sub_i(op_i == OP_SUB),
    .sum_o(sum), .cf_o(a_cf), .of_o(a_of), .af_o(a_af)
  );

  flag_alu_logic #(.WIDTH(WIDTH)) logic_i (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(lres)
  );

  assign res = is_arith ? sum : lres;

  flag_alu_flags #(.WIDTH(WIDTH), .PAR_BITS(PAR_BITS)) flags_i (
    .res_i(res), .sf_o(sf), .zf_o(zf), .pf_o(pf)
  );

  always_comb begin
    nxt.cf = is_arith & a_cf;
    nxt.of = is_arith & a_of;
    nxt.af = is_arith & a_af;
    nxt.sf = sf;
    nxt.zf = zf;
    nxt.pf = pf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      q        <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res;
        q        <= nxt;
      end
    end
  end

  assign carry_o    = q.cf;
  assign overflow_o = q.of;
  assign sign_o     = q.sf;
  assign zero_o     = q.zf;
  assign aux_o      = q.af;
  assign parity_o   = q.pf;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned PAR_BITS = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             valid_o,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             overflow_o,
  input logic             sign_o,
  input logic             zero_o,
  input logic             aux_o,
  input logic             parity_o
);
  logic [WIDTH-1:0] exp_sum;
  assign exp_sum = a_i + b_i;

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (!valid_o && result_o == '0 && !carry_o && !overflow_o &&
                               !sign_o && !zero_o && !aux_o && !parity_o); // R1
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_ADD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd0) |=> result_o == $past(exp_sum)); // R3
  AST_SUB_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd1) |=> carry_o == $past(a_i < b_i)); // R4
  AST_SIGN_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sign_o == result_o[WIDTH-1]); // R6
  AST_ZERO_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> zero_o == (result_o == '0)); // R7
  AST_PARITY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> parity_o == ~(^result_o[PAR_BITS-1:0])); // R9
  AST_LOGIC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= 3'd2) |=> (!carry_o && !overflow_o && !aux_o)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(carry_o) && $stable(overflow_o) &&
                  $stable(sign_o) && $stable(zero_o) && $stable(aux_o) &&
                  $stable(parity_o))); // R11
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH), .PAR_BITS(PAR_BITS)) chk_i (.*);

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        valid_o, carry_o, overflow_o, sign_o, zero_o, aux_o, parity_o;
  logic [31:0] result_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  flag_alu dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [37:0] model(input logic [2:0] op, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [32:0] w;
    logic [31:0] r;
    logic cf, of, af, pf;
    int n;
    cf = 0; of = 0; af = 0;
    case (op)
      3'd0: begin
        w = {1'b0, a} + {1'b0, b}; r = w[31:0]; cf = w[32];
        af = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
        of = (a[31] == b[31]) && (r[31] != a[31]);
      end
      3'd1: begin
        r = a - b; cf = a < b; af = a[3:0] < b[3:0];
        of = (a[31] != b[31]) && (r[31] != a[31]);
      end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      default: r = 32'd0;
    endcase
    n = 0;
    for (int i = 0; i < 8; i++) n += int'(r[i]);
    pf = (n % 2) == 0;
    return {r, cf, of, r[31], r == 32'd0, af, pf};
  endfunction

  task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [37:0] e;
    e = model(op, a, b);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R2 valid_o", 32'(valid_o), 32'd1);
    chk("R3 result", result_o, e[37:6]);
    chk("R4 carry", 32'(carry_o), 32'(e[5]));
    chk("R5 overflow", 32'(overflow_o), 32'(e[4]));
    chk("R6 sign", 32'(sign_o), 32'(e[3]));
    chk("R7 zero", 32'(zero_o), 32'(e[2]));
    chk("R8 aux", 32'(aux_o), 32'(e[1]));
    chk("R9 parity", 32'(parity_o), 32'(e[0]));
    if (op >= 3'd2)
      chk("R10 arith flags clear", {29'd0, carry_o, overflow_o, aux_o}, 32'd0);
  endtask

  initial begin
    logic [31:0] hold_r;
    logic [5:0]  hold_f;
    void'($urandom(32'h5eed_0a1b));
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid_o", 32'(valid_o), 32'd0);
    chk("R1 reset result", result_o, 32'd0);
    chk("R1 reset flags", {26'd0, carry_o, overflow_o, sign_o, zero_o, aux_o, parity_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2 idle valid_o", 32'(valid_o), 32'd0);

    run(3'd0, 32'h7FFF_FFFF, 32'h1);       // R5 signed overflow, R8 nibble carry
    run(3'd0, 32'hFFFF_FFFF, 32'h1);       // R4 carry, R7 zero
    run(3'd0, 32'h0000_0008, 32'h0000_0008); // R8 carry into bit 4
    run(3'd1, 32'h0, 32'h1);               // R4 borrow, R8 borrow
    run(3'd1, 32'h8000_0000, 32'h1);       // R5 overflow on sub
    run(3'd1, 32'h1234_5678, 32'h1234_5678); // R7 zero, no borrow
    run(3'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F); // R7 zero from AND
    run(3'd3, 32'hFF00_0000, 32'h0000_0001); // R9 upper bits ignored
    run(3'd4, 32'hFFFF_FFFF, 32'h0000_0003); // R10
    for (int k = 5; k < 8; k++) run(3'(k), 32'hDEAD_BEEF, 32'h1234_5678); // R3 unused codes

    // R11: idle cycle with new operands must not change outputs
    run(3'd0, 32'h0000_00F1, 32'h0000_0002);
    hold_r = result_o;
    hold_f = {carry_o, overflow_o, sign_o, zero_o, aux_o, parity_o};
    @(negedge clk_i);
    op_i = 3'd1; a_i = 32'h0; b_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    chk("R11 hold valid_o", 32'(valid_o), 32'd0);
    chk("R11 hold result", result_o, hold_r);
    chk("R11 hold flags", 32'(hold_f),
        32'({carry_o, overflow_o, sign_o, zero_o, aux_o, parity_o}));

    // R2 back-to-back valid
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 3'd0; a_i = 32'd5; b_i = 32'd6;
    @(negedge clk_i);
    op_i = 3'd1; a_i = 32'd5; b_i = 32'd6;
    chk("R2 first of pair", result_o, 32'd11);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R2 second of pair", result_o, 32'hFFFF_FFFF);
    chk("R4 second of pair borrow", 32'(carry_o), 32'd1);

    for (int n = 0; n < 1500; n++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = ($urandom() % 4 == 0) ? (ra ^ ($urandom() & 32'hF)) : $urandom();
      run(3'($urandom() % 8), ra, rb);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule